// File: doc/BRIEF.md
# Transmit Direction Control for a Two-Wire Serial Line

This block produces the registered level of the request-to-send pin of one UART channel. That pin also serves as the driver enable of a half-duplex line transceiver. The block picks one of three owners for the pin:

- a software modem-control bit,
- the request produced by hardware flow control,
- an automatic mode in which the transmitter itself owns the pin.

In automatic mode the pin becomes active on the first host write into the transmit FIFO. It stays active until the final stop bit of the final character has left the shift register. A polarity bit can swap the active and idle levels of the pin, and it does so in automatic mode only.

Under the usual convention for modem-control pins, the pin is active low. A software or flow-control request of 1 therefore drives the pin to 0. The serializer, the FIFOs and the baud generator lie outside the block. They report to it through a FIFO write pulse, two empty flags and a one-cycle end-of-stop-bit strobe. All interfaces are plain level or pulse signals, so there is no valid/ready handshake and no back-pressure.

Top module: `txdir_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, the pin is loaded with its idle level for the selected mode: 0 if `auto_en` and `auto_inv` are both 1, and 1 otherwise. Reset also clears the pending-data state.
- R2: With `auto_en`=0 and `hwfc_en`=0, the pin equals the inverse of `sw_rts` one clock after it is sampled.
- R3: With `auto_en`=0 and `hwfc_en`=1, the pin equals the inverse of `flow_rts` one clock after it is sampled, and `sw_rts` has no effect.
- R4: With `auto_en`=1, neither `sw_rts`, `flow_rts` nor `hwfc_en` affects the pin.
- R5: In automatic mode with `auto_inv`=0, a `fifo_wr` pulse drives the pin to 0 on the next clock.
- R6: Once data is pending, the pin stays active on every cycle until `stop_done` is sampled together with both `fifo_empty`=1 and `tsr_empty`=1. A strobe with either flag low, or the empty flags without a strobe, leaves the pin active.
- R7: The cycle after `stop_done`, `fifo_empty` and `tsr_empty` are sampled high together (with no write), the pin returns to its idle level.
- R8: A `fifo_wr` sampled in the same cycle as the final stop strobe keeps the pin active with no idle cycle in between.
- R9: In automatic mode with `auto_inv`=1, the pin is 0 while idle and 1 while data is pending.
- R10: Outside automatic mode, `auto_inv` has no effect on the pin.
- R11: A change of `auto_en` or `hwfc_en` takes effect on the pin one clock after it is sampled. Pending-data state is tracked in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_en | input | 1 | Automatic direction mode enable (highest priority) |
| auto_inv | input | 1 | Swap pin polarity in automatic mode |
| hwfc_en | input | 1 | Hardware flow control owns the pin when automatic mode is off |
| sw_rts | input | 1 | Software request bit; 1 asks for pin low |
| flow_rts | input | 1 | Flow-control request; 1 asks for pin low |
| fifo_wr | input | 1 | One-cycle pulse per host write into the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| stop_done | input | 1 | One-cycle strobe at the end of each stop bit |
| rts_pin | output | 1 | Registered pin level |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it are sampled. This holds for reset, source selection, the pin going active on a write and the pin releasing on the final strobe, because the pin register is fed by the next-state value of the pending flag. The bench therefore changes inputs on the falling edge and reads `rts_pin` 1 ns after the following rising edge. In the hold scenarios it reads the pin again after each further edge, so that a one-cycle idle glitch would be caught.

// File: rtl/txdir_pkg.sv
package txdir_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT = 2'd0,
    SRC_FLOW = 2'd1,
    SRC_AUTO = 2'd2
  } rts_src_e;

  // Pin level for an active request: active-low unless swapped.
  function automatic logic pin_level(input logic active, input logic swap);
    return swap ? active : ~active;
  endfunction

endpackage

// File: rtl/txdir_busy.sv
module txdir_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_wr_i,
  input  logic fifo_empty_i,
  input  logic tsr_empty_i,
  input  logic stop_done_i,
  output logic busy_o,
  output logic busy_next_o
);

  logic line_drained;
  logic busy_q;

  // The last stop bit has completed with nothing left behind it.
  assign line_drained = stop_done_i & fifo_empty_i & tsr_empty_i;

  // A write always wins over the drain strobe of the same cycle.
  assign busy_next_o = fifo_wr_i | (busy_q & ~line_drained);

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_next_o;
  end

  assign busy_o = busy_q;

  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_i |=> busy_o); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(stop_done_i && fifo_empty_i && tsr_empty_i)) |=> busy_o); // R6

  AST_BUSY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stop_done_i && fifo_empty_i && tsr_empty_i && !fifo_wr_i) |=> !busy_o); // R7

endmodule

// File: rtl/txdir_select.sv
module txdir_select
  import txdir_pkg::*;
(
  input  logic auto_en_i,
  input  logic auto_inv_i,
  input  logic hwfc_en_i,
  input  logic sw_rts_i,
  input  logic flow_rts_i,
  input  logic busy_next_i,
  output logic active_o,
  output logic swap_o
);

  rts_src_e src;

  // Automatic mode outranks flow control, which outranks software.
  always_comb begin
    if (auto_en_i)      src = SRC_AUTO;
    else if (hwfc_en_i) src = SRC_FLOW;
    else                src = SRC_SOFT;
  end

  always_comb begin
    unique case (src)
      SRC_AUTO: active_o = busy_next_i;
      SRC_FLOW: active_o = flow_rts_i;
      default:  active_o = sw_rts_i;
    endcase
  end

  // Polarity swap applies only while the transmitter owns the pin.
  assign swap_o = (src == SRC_AUTO) & auto_inv_i;

  always_comb begin
    if (!auto_en_i) begin
      AST_SWAP_ONLY_AUTO: assert (!swap_o); // R10
    end
  end

endmodule

// File: rtl/txdir_pin.sv
module txdir_pin
  import txdir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic swap_i,
  input  logic auto_en_i,
  input  logic auto_inv_i,
  output logic pin_o
);

  logic pin_q;
  logic idle_level;

  // Idle level for the mode selected during reset.
  assign idle_level = pin_level(1'b0, auto_en_i & auto_inv_i);

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= idle_level;
    else        pin_q <= pin_level(active_i, swap_i);
  end

  assign pin_o = pin_q;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (pin_o == !($past(auto_en_i) && $past(auto_inv_i)))); // R1

endmodule

// File: rtl/txdir_ctrl.sv
module txdir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic auto_inv,
  input  logic hwfc_en,
  input  logic sw_rts,
  input  logic flow_rts,
  input  logic fifo_wr,
  input  logic fifo_empty,
  input  logic tsr_empty,
  input  logic stop_done,
  output logic rts_pin
);

  logic busy;
  logic busy_next;
  logic active;
  logic swap;

  txdir_busy u_busy (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_wr_i    (fifo_wr),
    .fifo_empty_i (fifo_empty),
    .tsr_empty_i  (tsr_empty),
    .stop_done_i  (stop_done),
    .busy_o       (busy),
    .busy_next_o  (busy_next)
  );

  txdir_select u_sel (
    .auto_en_i   (auto_en),
    .auto_inv_i  (auto_inv),
    .hwfc_en_i   (hwfc_en),
    .sw_rts_i    (sw_rts),
    .flow_rts_i  (flow_rts),
    .busy_next_i (busy_next),
    .active_o    (active),
    .swap_o      (swap)
  );

  txdir_pin u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .swap_i     (swap),
    .auto_en_i  (auto_en),
    .auto_inv_i (auto_inv),
    .pin_o      (rts_pin)
  );

  AST_SOFT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !hwfc_en) |=> (rts_pin == !$past(sw_rts))); // R2

  AST_FLOW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && hwfc_en) |=> (rts_pin == !$past(flow_rts))); // R3

  AST_AUTO_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |=> (rts_pin == ($past(auto_inv) ? busy : !busy))); // R4

  AST_WRITE_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !auto_inv && fifo_wr) |=> !rts_pin); // R5

  AST_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && !auto_inv && busy && fifo_wr && stop_done) |=> !rts_pin); // R8

endmodule

// File: tb/txdir_ctrl_test.sv
`timescale 1ns/1ps
module txdir_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, auto_inv = 1'b0, hwfc_en = 1'b0;
  logic sw_rts = 1'b0, flow_rts = 1'b0;
  logic fifo_wr = 1'b0, fifo_empty = 1'b1, tsr_empty = 1'b1, stop_done = 1'b0;
  logic rts_pin;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  txdir_ctrl uut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .auto_inv(auto_inv),
    .hwfc_en(hwfc_en), .sw_rts(sw_rts), .flow_rts(flow_rts),
    .fifo_wr(fifo_wr), .fifo_empty(fifo_empty), .tsr_empty(tsr_empty),
    .stop_done(stop_done), .rts_pin(rts_pin)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (rts_pin !== exp) begin
      errors++;
      $display("FAIL %s: rts_pin=%b expected=%b at %0t", req, rts_pin, exp, $time);
    end
  endtask

  // Inputs already set on a falling edge; sample after the next rising edge.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive_edge();
    @(negedge clk);
  endtask

  task automatic pulse_write();
    drive_edge(); fifo_wr = 1'b1; fifo_empty = 1'b0; tsr_empty = 1'b0;
    tick();
    drive_edge(); fifo_wr = 1'b0;
  endtask

  task automatic drain(input logic exp_after, input string req);
    fifo_empty = 1'b1; tsr_empty = 1'b1; stop_done = 1'b1;
    tick(); chk(req, exp_after);
    drive_edge(); stop_done = 1'b0;
  endtask

  task automatic do_reset(input logic ae, input logic ai, input logic exp);
    drive_edge(); rst_n = 1'b0; auto_en = ae; auto_inv = ai;
    tick(); chk("R1 reset idle level", exp);
    tick(); chk("R1 reset idle level held", exp);
    drive_edge(); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0, 1'b1);
    do_reset(1'b1, 1'b1, 1'b0);
    do_reset(1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_soft();
    drive_edge(); auto_en = 0; auto_inv = 0; hwfc_en = 0; sw_rts = 1;
    tick(); chk("R2 soft request drives low", 1'b0);
    drive_edge(); sw_rts = 0;
    tick(); chk("R2 soft release drives high", 1'b1);
    drive_edge(); auto_inv = 1;
    tick(); chk("R10 invert ignored, soft idle", 1'b1);
    drive_edge(); sw_rts = 1;
    tick(); chk("R10 invert ignored, soft active", 1'b0);
    drive_edge(); auto_inv = 0; sw_rts = 0;
    tick();
  endtask

  task automatic t_flow();
    drive_edge(); hwfc_en = 1; flow_rts = 1; sw_rts = 0;
    tick(); chk("R3 flow request drives low", 1'b0);
    drive_edge(); flow_rts = 0; sw_rts = 1;
    tick(); chk("R3 flow release, soft ignored", 1'b1);
    drive_edge(); auto_inv = 1;
    tick(); chk("R10 invert ignored under flow control", 1'b1);
    drive_edge(); hwfc_en = 0; auto_inv = 0; sw_rts = 0;
    tick();
  endtask

  task automatic t_auto_basic();
    drive_edge(); auto_en = 1; sw_rts = 1; hwfc_en = 1; flow_rts = 1;
    tick(); chk("R4 R11 auto idle overrides soft and flow", 1'b1);
    pulse_write(); chk("R5 write drives pin low", 1'b0);
    drive_edge(); sw_rts = 0; flow_rts = 0; hwfc_en = 0;
    tick(); chk("R4 soft and flow changes ignored while busy", 1'b0);
    drive_edge(); fifo_empty = 0; tsr_empty = 1; stop_done = 1;
    tick(); chk("R6 strobe with fifo not empty holds", 1'b0);
    drive_edge(); fifo_empty = 1; tsr_empty = 0;
    tick(); chk("R6 strobe with shift register busy holds", 1'b0);
    drive_edge(); tsr_empty = 1; stop_done = 0;
    tick(); chk("R6 empties without strobe hold", 1'b0);
    drive_edge(); drain(1'b1, "R7 final stop bit releases pin");
    tick(); chk("R7 pin stays idle", 1'b1);
  endtask

  task automatic t_glitch();
    pulse_write(); chk("R5 write before overlap", 1'b0);
    drive_edge(); fifo_wr = 1; fifo_empty = 1; tsr_empty = 1; stop_done = 1;
    tick(); chk("R8 write on final strobe keeps active", 1'b0);
    drive_edge(); fifo_wr = 0; stop_done = 0; fifo_empty = 0; tsr_empty = 0;
    tick(); chk("R8 still active after overlap", 1'b0);
    drive_edge(); drain(1'b1, "R7 release after overlapped write");
  endtask

  task automatic t_invert();
    drive_edge(); auto_inv = 1;
    tick(); chk("R9 inverted idle is low", 1'b0);
    pulse_write(); chk("R9 inverted active is high", 1'b1);
    drive_edge(); drain(1'b0, "R9 inverted release goes low");
    drive_edge(); auto_inv = 0;
    tick();
  endtask

  task automatic t_mode_change();
    pulse_write(); chk("R5 write before mode change", 1'b0);
    drive_edge(); auto_en = 0; sw_rts = 0; hwfc_en = 0;
    tick(); chk("R11 leaving auto hands pin to software", 1'b1);
    drive_edge(); auto_en = 1;
    tick(); chk("R11 busy tracked while manual, auto resumes active", 1'b0);
    drive_edge(); drain(1'b1, "R7 release after mode change");
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    t_soft();
    t_flow();
    t_auto_basic();
    t_glitch();
    t_invert();
    t_mode_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule